// File: doc/BRIEF.md
# DMA Channel Run-Control Register

This block is the run-control word of a multi-channel DMA engine. For every channel it holds three control bits: enable, suspend and abort. Each bit has a companion write-enable bit in the same 64-bit word, and a software write changes a control bit only when its companion is set in that write. Software can therefore start, pause, resume, stop or kill one channel without first reading the word back.

The channel logic is modelled by two inputs per channel. One reports that the channel has drained after a stop request. The other reports that an abort has completed. A stop request does not clear the enable bit immediately. The enable bit stays set, and a disable request is held towards the channel, until the channel reports that it has drained. A channel that gets no handshake from its peripheral never drains, so it stays enabled until software aborts it. When an abort completes, the channel's control bits clear and a one-cycle abort interrupt pulse is raised. The block also derives a two-bit state for each channel.

Top module: `chen_reg`

## Requirements
- R1: After reset every control bit, every pending stop, every interrupt pulse and every output is 0, and every channel reads as idle.
- R2: For channel n, the enable bit is at bit n and its write-enable at bit 8+n. A write sets enable to the written value only when the write-enable is 1. When the write-enable is 0 the enable bit is left unchanged. A write to one channel leaves the other channels unchanged.
- R3: For channel n, the suspend bit is at bit 16+n and its write-enable at bit 24+n. Writing suspend=0 with its write-enable=1 resumes the channel.
- R4: For channel n, the abort bit is at bit 32+n and its write-enable at bit 40+n. A set abort bit drives the channel's abort-request output.
- R5: If abort-complete arrives while the abort bit is set, the enable, suspend, abort and pending-stop bits of that channel clear on the next edge. At the same edge the channel's abort interrupt goes high for exactly one cycle.
- R6: Writing enable=0 with its write-enable=1 while enable is set does not clear enable. Instead it raises the channel's disable-request output. A later drained indication clears enable, suspend and the disable request.
- R7: Without a drained indication, a stopping channel stays enabled for any number of cycles until an abort completes.
- R8: The state of channel n is at chState[2n+1:2n]. The encoding is 00 idle, 01 active (enable set), 10 suspended (enable clear, suspend set). Active takes priority over suspended, and 11 never occurs.
- R9: Write-enable bit positions, positions of channels beyond the configured count, and bits 48..63 read as 0. A write to a position of a channel that does not exist changes nothing.
- R10: When a software write and a channel completion fall in the same cycle, the completion is applied first and the write second. An enable=1 write therefore leaves the channel enabled after an abort completes, while the abort bit still clears and the interrupt still pulses.
- R11: A drained indication with no stop pending, or an abort-complete with no abort bit set, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrValid | input | 1 | Register write strobe |
| wrData | input | 64 | Register write data |
| rdData | output | 64 | Current register value |
| chDrained | input | NUM_CH | Channel has drained after a stop request |
| chAbortDone | input | NUM_CH | Channel has finished an abort |
| chEnable | output | NUM_CH | Per-channel enable |
| chSuspend | output | NUM_CH | Per-channel suspend |
| chAbortReq | output | NUM_CH | Per-channel abort request |
| chDisableReq | output | NUM_CH | Per-channel pending stop request |
| chAbortIrq | output | NUM_CH | One-cycle abort-complete interrupt |
| chState | output | 2*NUM_CH | Per-channel state, two bits each |

## Verification
The two functions that can coincide are a software write and a channel-side completion (abort done or drained) on the same channel in the same cycle. The bench provokes this by arming an abort on a channel and then, in a single cycle, asserting abort-complete together with an enable=1 write to that channel. The cycle after that edge is judged as follows: the enable bit must remain set, suspend and abort must read 0, and the abort interrupt must pulse. Separately, completions that arrive with nothing pending are checked to leave the register untouched.

// File: rtl/chen_pkg.sv
package chen_pkg;
  localparam int REG_W      = 64;
  localparam int FIELD_SPAN = 8;
  localparam int EN_LSB     = 0;
  localparam int EN_WE_LSB  = 8;
  localparam int SU_LSB     = 16;
  localparam int SU_WE_LSB  = 24;
  localparam int AB_LSB     = 32;
  localparam int AB_WE_LSB  = 40;

  typedef enum logic [1:0] {
    CH_IDLE   = 2'b00,
    CH_ACTIVE = 2'b01,
    CH_SUSP   = 2'b10
  } chState_t;

  typedef struct packed {
    logic enWe;
    logic enVal;
    logic suWe;
    logic suVal;
    logic abWe;
    logic abVal;
    logic abortHit;
    logic drainHit;
  } chStrobe_t;
endpackage

// File: rtl/chen_ctrl.sv
module chen_ctrl
  import chen_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                     wrValid,
  input  logic [REG_W-1:0]         wrData,
  input  logic [NUM_CH-1:0]        chDrained,
  input  logic [NUM_CH-1:0]        chAbortDone,
  input  logic [NUM_CH-1:0]        abortQ,
  input  logic [NUM_CH-1:0]        pendQ,
  output chStrobe_t [NUM_CH-1:0]   strb
);
  for (genvar i = 0; i < NUM_CH; i++) begin : gStrb
    always_comb begin
      strb[i].enWe     = wrValid & wrData[EN_WE_LSB + i];
      strb[i].enVal    = wrData[EN_LSB + i];
      strb[i].suWe     = wrValid & wrData[SU_WE_LSB + i];
      strb[i].suVal    = wrData[SU_LSB + i];
      strb[i].abWe     = wrValid & wrData[AB_WE_LSB + i];
      strb[i].abVal    = wrData[AB_LSB + i];
      strb[i].abortHit = chAbortDone[i] & abortQ[i];
      strb[i].drainHit = chDrained[i] & pendQ[i];
    end
  end
endmodule

// File: rtl/chen_dp.sv
module chen_dp
  import chen_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  chStrobe_t [NUM_CH-1:0]  strb,
  output logic [NUM_CH-1:0]       enQ,
  output logic [NUM_CH-1:0]       suQ,
  output logic [NUM_CH-1:0]       abQ,
  output logic [NUM_CH-1:0]       pendQ,
  output logic [NUM_CH-1:0]       irqQ,
  output logic [REG_W-1:0]        rdData,
  output logic [2*NUM_CH-1:0]     chState
);
  logic [NUM_CH-1:0] enD, suD, abD, pendD, irqD;

  for (genvar i = 0; i < NUM_CH; i++) begin : gCh
    // Channel completion first, software write second.
    always_comb begin
      enD[i]   = enQ[i];
      suD[i]   = suQ[i];
      abD[i]   = abQ[i];
      pendD[i] = pendQ[i];
      irqD[i]  = 1'b0;
      if (strb[i].abortHit) begin
        enD[i]   = 1'b0;
        suD[i]   = 1'b0;
        abD[i]   = 1'b0;
        pendD[i] = 1'b0;
        irqD[i]  = 1'b1;
      end else if (strb[i].drainHit) begin
        enD[i]   = 1'b0;
        suD[i]   = 1'b0;
        pendD[i] = 1'b0;
      end
      if (strb[i].enWe) begin
        if (strb[i].enVal) begin
          enD[i]   = 1'b1;
          pendD[i] = 1'b0;
        end else if (enD[i]) begin
          pendD[i] = 1'b1;
        end
      end
      if (strb[i].suWe) suD[i] = strb[i].suVal;
      if (strb[i].abWe) abD[i] = strb[i].abVal;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ[i]   <= 1'b0;
        suQ[i]   <= 1'b0;
        abQ[i]   <= 1'b0;
        pendQ[i] <= 1'b0;
        irqQ[i]  <= 1'b0;
      end else begin
        enQ[i]   <= enD[i];
        suQ[i]   <= suD[i];
        abQ[i]   <= abD[i];
        pendQ[i] <= pendD[i];
        irqQ[i]  <= irqD[i];
      end
    end

    always_comb begin
      if (enQ[i])      chState[2*i +: 2] = CH_ACTIVE;
      else if (suQ[i]) chState[2*i +: 2] = CH_SUSP;
      else             chState[2*i +: 2] = CH_IDLE;
    end

    AST_WRITE_GATE: assert property (@(posedge clk) disable iff (!rstN)
      (!strb[i].enWe && !strb[i].abortHit && !strb[i].drainHit) |=> $stable(enQ[i])); // R2
    AST_ABORT_DONE: assert property (@(posedge clk) disable iff (!rstN)
      (strb[i].abortHit && !strb[i].enWe && !strb[i].suWe) |=> (!enQ[i] && !suQ[i] && irqQ[i])); // R5
    AST_DRAIN_DONE: assert property (@(posedge clk) disable iff (!rstN)
      (strb[i].drainHit && !strb[i].enWe && !strb[i].suWe) |=> (!enQ[i] && !suQ[i] && !pendQ[i])); // R6
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
      (strb[i].enWe && strb[i].enVal) |=> (enQ[i] && !pendQ[i])); // R10
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
      chState[2*i +: 2] != 2'b11); // R8
  end

  always_comb begin
    rdData = '0;
    rdData[EN_LSB +: NUM_CH] = enQ;
    rdData[SU_LSB +: NUM_CH] = suQ;
    rdData[AB_LSB +: NUM_CH] = abQ;
  end
endmodule

// File: rtl/chen_reg.sv
module chen_reg
  import chen_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrValid,
  input  logic [63:0]          wrData,
  output logic [63:0]          rdData,
  input  logic [NUM_CH-1:0]    chDrained,
  input  logic [NUM_CH-1:0]    chAbortDone,
  output logic [NUM_CH-1:0]    chEnable,
  output logic [NUM_CH-1:0]    chSuspend,
  output logic [NUM_CH-1:0]    chAbortReq,
  output logic [NUM_CH-1:0]    chDisableReq,
  output logic [NUM_CH-1:0]    chAbortIrq,
  output logic [2*NUM_CH-1:0]  chState
);
  initial begin
    if (NUM_CH < 1 || NUM_CH > FIELD_SPAN) $error("NUM_CH out of range");
  end

  chStrobe_t [NUM_CH-1:0] strb;
  logic [NUM_CH-1:0] abQ, pendQ;

  chen_ctrl #(.NUM_CH(NUM_CH)) uCtrl (
    .wrValid     (wrValid),
    .wrData      (wrData),
    .chDrained   (chDrained),
    .chAbortDone (chAbortDone),
    .abortQ      (abQ),
    .pendQ       (pendQ),
    .strb        (strb)
  );

  chen_dp #(.NUM_CH(NUM_CH)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .enQ     (chEnable),
    .suQ     (chSuspend),
    .abQ     (abQ),
    .pendQ   (pendQ),
    .irqQ    (chAbortIrq),
    .rdData  (rdData),
    .chState (chState)
  );

  assign chAbortReq   = abQ;
  assign chDisableReq = pendQ;
endmodule

// File: tb/sim_chen_reg.sv
module sim_chen_reg;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0;
  logic [63:0] wrData = '0;
  logic [N-1:0] chDrained = '0, chAbortDone = '0;
  logic [63:0] rdData;
  logic [N-1:0] chEnable, chSuspend, chAbortReq, chDisableReq, chAbortIrq;
  logic [2*N-1:0] chState;

  always #4 clk = ~clk;

  chen_reg #(.NUM_CH(N)) u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData), .rdData(rdData),
    .chDrained(chDrained), .chAbortDone(chAbortDone), .chEnable(chEnable),
    .chSuspend(chSuspend), .chAbortReq(chAbortReq), .chDisableReq(chDisableReq),
    .chAbortIrq(chAbortIrq), .chState(chState)
  );

  typedef struct {
    logic [3:0] en, su, ab, dis, irq;
    string      tag;
  } exp_t;

  exp_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // R8 encoding: 00 idle, 01 active, 10 suspended
  function automatic logic [7:0] stateOf(input logic [3:0] en, input logic [3:0] su);
    logic [7:0] s = '0;
    for (int i = 0; i < 4; i++)
      s[2*i +: 2] = en[i] ? 2'b01 : (su[i] ? 2'b10 : 2'b00);
    return s;
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [63:0] d, input logic [3:0] drn,
                      input logic [3:0] abd, input logic [3:0] en, input logic [3:0] su,
                      input logic [3:0] ab, input logic [3:0] dis, input logic [3:0] irq,
                      input string tag);
    exp_t e;
    @(negedge clk);
    wrValid = wr; wrData = d; chDrained = drn; chAbortDone = abd;
    e.en = en; e.su = su; e.ab = ab; e.dis = dis; e.irq = irq; e.tag = tag;
    expQ.push_back(e);
  endtask

  function automatic logic [63:0] bit64(input int p);
    return 64'd1 << p;
  endfunction

  // Monitor: compares each expected item after the edge that follows its drive.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        exp_t e;
        logic [63:0] expRd;
        e = expQ.pop_front();
        expRd = {16'b0, 12'b0, e.ab, 12'b0, e.su, 12'b0, e.en};
        check(e.tag, "rdData", rdData, expRd);
        check(e.tag, "chState", {56'b0, chState}, {56'b0, stateOf(e.en, e.su)});
        check(e.tag, "enable/suspend/abortReq", {52'b0, chEnable, chSuspend, chAbortReq},
              {52'b0, e.en, e.su, e.ab});
        check(e.tag, "disableReq", {60'b0, chDisableReq}, {60'b0, e.dis});
        check(e.tag, "abortIrq", {60'b0, chAbortIrq}, {60'b0, e.irq});
      end
    end
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    //    wr  data                                          drn    abd    en     su     ab     dis    irq
    step(0, 0, 4'b0, 4'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, "R1 reset");
    step(1, bit64(0)|bit64(8)|bit64(1), 4'b0, 4'b0, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000, "R2 enable ch0, ch1 without we");
    step(1, bit64(2)|bit64(10)|bit64(9), 4'b0, 4'b0, 4'b0101, 4'b0000, 4'b0000, 4'b0000, 4'b0000, "R2 enable ch2 only, R9 we reads 0");
    step(1, bit64(16)|bit64(24), 4'b0, 4'b0, 4'b0101, 4'b0001, 4'b0000, 4'b0000, 4'b0000, "R3 suspend ch0, R8 active wins");
    step(1, bit64(7)|bit64(15)|bit64(23)|bit64(31)|bit64(39)|bit64(47)|bit64(63), 4'b0, 4'b0,
         4'b0101, 4'b0001, 4'b0000, 4'b0000, 4'b0000, "R9 absent channel ignored");
    step(1, bit64(24), 4'b0, 4'b0, 4'b0101, 4'b0000, 4'b0000, 4'b0000, 4'b0000, "R3 resume ch0");
    step(1, bit64(10), 4'b0, 4'b0, 4'b0101, 4'b0000, 4'b0000, 4'b0100, 4'b0000, "R6 stop ch2 keeps enable");
    step(0, 0, 4'b0001, 4'b0, 4'b0101, 4'b0000, 4'b0000, 4'b0100, 4'b0000, "R11 drained without stop");
    step(1, bit64(18)|bit64(26), 4'b0, 4'b0, 4'b0101, 4'b0100, 4'b0000, 4'b0100, 4'b0000, "R3 suspend ch2");
    step(0, 0, 4'b0100, 4'b0, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000, "R6 drained clears ch2");
    step(1, bit64(1)|bit64(9), 4'b0, 4'b0, 4'b0011, 4'b0000, 4'b0000, 4'b0000, 4'b0000, "R2 enable ch1");
    step(1, bit64(9), 4'b0, 4'b0, 4'b0011, 4'b0000, 4'b0000, 4'b0010, 4'b0000, "R6 stop ch1");
    for (int k = 0; k < 5; k++)
      step(0, 0, 4'b0, 4'b0, 4'b0011, 4'b0000, 4'b0000, 4'b0010, 4'b0000, "R7 no drain stays enabled");
    step(1, bit64(33)|bit64(41), 4'b0, 4'b0, 4'b0011, 4'b0000, 4'b0010, 4'b0010, 4'b0000, "R4 abort ch1");
    step(0, 0, 4'b0, 4'b0010, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0010, "R5 abort done ch1");
    step(0, 0, 4'b0, 4'b0, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000, "R5 irq single cycle");
    step(0, 0, 4'b0, 4'b0001, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000, "R11 abort done without abort");
    step(1, bit64(19)|bit64(27), 4'b0, 4'b0, 4'b0001, 4'b1000, 4'b0000, 4'b0000, 4'b0000, "R8 ch3 suspended");
    step(1, bit64(32)|bit64(40), 4'b0, 4'b0, 4'b0001, 4'b1000, 4'b0001, 4'b0000, 4'b0000, "R4 abort ch0");
    step(1, bit64(0)|bit64(8), 4'b0, 4'b0001, 4'b0001, 4'b1000, 4'b0000, 4'b0000, 4'b0001, "R10 write and abort done together");
    step(0, 0, 4'b0, 4'b0, 4'b0001, 4'b1000, 4'b0000, 4'b0000, 4'b0000, "R10 settled");
    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule